// File: doc/BRIEF.md
# Relative Branch Cycle Sequencer

This block sequences the bus cycles of a two-byte relative branch instruction. Once it is launched with the address of the branch opcode, it drives the address bus for each cycle. It fetches the opcode and then the signed offset byte. It then walks through the short or long form of the branch, depending on the resolved branch condition and on whether the target lies in another 256-byte page. On every cycle it reports whether the byte on the data bus is the opcode of the following instruction or a read that is thrown away.

A branch that is not taken costs two cycles after the offset fetch stage begins. A taken branch that stays within its page costs three. A taken branch into another page costs four. In the two short forms the first cycle of the next instruction is spent inside the branch itself, so the block hands back to the main sequencer in the second-fetch state. The long form hands back in that same state and also asserts the late register-writeback flag. A ready input stalls the whole sequence without disturbing any output.

Top module: `branch_cycle_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle: phase is 0, addr is 0, and next_op, discard, hand_t1f and hand_t1 are all 0. A start request during reset is ignored.
- R2: The phase output uses this encoding: 0 idle, 1 opcode fetch, 2 offset fetch, 3 third cycle, 4 fourth cycle, 5 carry-fix cycle, 6 hand-off. When start is high in idle at a ready edge, the block captures pc_in and enters phase 1 with addr equal to the captured value. Phase 1 always advances to phase 2.
- R3: In phase 2, addr is PC+1. At the ready edge that ends phase 2, data_in is latched as the signed two's-complement offset and take is latched as the branch condition.
- R4: In phase 3 addr is PC+2. If the branch is not taken, next_op is 1 and discard is 0. The next phase is 6 with addr PC+3, hand_t1f 1 and hand_t1 0.
- R5: If the branch is taken, phase 3 has discard 1 and next_op 0. It is followed by phase 4, whose addr has the high byte of PC+2 and the low byte of (PC+2 + offset) with no carry into the high byte.
- R6: If the branch is taken and the high byte of the target PC+2+sext(offset) equals the high byte of PC+2, phase 4 has next_op 1. The next phase is 6 with addr target+1, hand_t1f 1 and hand_t1 0.
- R7: If the branch is taken and those high bytes differ, in either direction, phase 4 has discard 1. Phase 5 follows, with addr equal to the full carry-corrected target and next_op 1. Phase 6 then follows with addr target+1 and both hand_t1f and hand_t1 set to 1.
- R8: Phase 6 lasts exactly one ready cycle and is followed by idle.
- R9: While rdy is low, phase, addr, next_op, discard, hand_t1f and hand_t1 hold their values. The data_in, take and start inputs sampled during the stall have no effect.
- R10: A start request outside idle is ignored, and so is a change of pc_in after capture.
- R11: next_op and discard are never high together, and hand_t1 is never high without hand_t1f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rdy | input | 1 | Ready; low stalls the sequence |
| start | input | 1 | Launch a branch sequence from idle |
| pc_in | input | ADDR_W (16) | Address of the branch opcode, captured at launch |
| data_in | input | OFS_W (8) | Data bus; offset byte sampled at end of phase 2 |
| take | input | 1 | Resolved branch condition, sampled with the offset |
| addr | output | ADDR_W (16) | Address bus value for the current cycle |
| next_op | output | 1 | Byte read this cycle is the next instruction's opcode |
| discard | output | 1 | Byte read this cycle is thrown away |
| hand_t1f | output | 1 | Hand-off: next instruction continues in second-fetch state |
| hand_t1 | output | 1 | Hand-off: late writeback flag, page-crossing form only |
| phase | output | 3 | Current cycle code, encoding in R2 |

## Verification
A ready stall can land on the same cycle in which the offset and the branch condition are sampled. It can also land on the cycle in which the page-crossing verdict chooses between fetching the opcode and discarding the read. The bench provokes this by lowering rdy in phase 2, 3, 4, 5 or 6 on a subset of a sweep over every offset byte. The sweep uses program counters placed on and near page edges and at both ends of the address space. During each stall the bench drives the inverted offset, the inverted condition and a stray start with a wrong pc_in. It then checks that every output holds through the stall. It also checks that the cycles after the stall follow the arithmetic expected from the true values, with the long form taken exactly when the high bytes of PC+2 and the target differ.

// File: rtl/brseq_pkg.sv
// Package brseq_pkg
// Shared cycle-phase encoding for the relative branch cycle sequencer.
// Assumes a three-bit phase code visible at the top-level ports.
package brseq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T0   = 3'd1,
        PH_T1   = 3'd2,
        PH_T2   = 3'd3,
        PH_T3   = 3'd4,
        PH_FIX  = 3'd5,
        PH_HAND = 3'd6
    } phase_e;
endpackage

// File: rtl/brseq_target.sv
// Module brseq_target
// Pure address arithmetic for a relative branch: the two opcode-fetch
// increments, the target with and without the carry into the page byte,
// the page-crossing verdict and the hand-off addresses.
// Assumes ADDR_W > OFS_W and a signed two's-complement offset; the page
// byte is everything above the low OFS_W address bits.
module brseq_target #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [OFS_W-1:0]  off_q,
    output logic [ADDR_W-1:0] pc_p1,
    output logic [ADDR_W-1:0] pc_p2,
    output logic [ADDR_W-1:0] tgt_nocarry,
    output logic [ADDR_W-1:0] tgt_full,
    output logic [ADDR_W-1:0] seq_after_pc2,
    output logic [ADDR_W-1:0] seq_after_tgt,
    output logic              page_cross
);
    localparam int HI_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] off_sext;
    logic [OFS_W-1:0]  low_sum;

    // Sign-extend the offset and form both target variants.
    always_comb begin
        off_sext      = {{HI_W{off_q[OFS_W-1]}}, off_q};
        pc_p1         = pc_q + ADDR_W'(1);
        pc_p2         = pc_q + ADDR_W'(2);
        tgt_full      = pc_p2 + off_sext;
        low_sum       = pc_p2[OFS_W-1:0] + off_q;
        tgt_nocarry   = {pc_p2[ADDR_W-1:OFS_W], low_sum};
        page_cross    = (tgt_full[ADDR_W-1:OFS_W] != pc_p2[ADDR_W-1:OFS_W]);
        seq_after_pc2 = pc_p2 + ADDR_W'(1);
        seq_after_tgt = tgt_full + ADDR_W'(1);
    end
endmodule

// File: rtl/brseq_fsm.sv
// Module brseq_fsm
// Cycle-phase state machine for a relative branch. Captures the opcode
// address at launch, and the offset and branch condition at the end of
// the offset-fetch phase. Every transition and capture waits for rdy.
// Assumes the caller launches only from idle; a launch in any other
// phase is ignored.
module brseq_fsm
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [OFS_W-1:0]  data_in,
    input  logic              take,
    input  logic              page_cross,
    output phase_e            ph_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [OFS_W-1:0]  off_q,
    output logic              take_q
);
    phase_e ph_d;

    // Next-phase selection from the current phase and the branch verdicts.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (start) ph_d = PH_T0;
            PH_T0:   ph_d = PH_T1;
            PH_T1:   ph_d = PH_T2;
            PH_T2:   ph_d = take_q ? PH_T3 : PH_HAND;
            PH_T3:   ph_d = page_cross ? PH_FIX : PH_HAND;
            PH_FIX:  ph_d = PH_HAND;
            PH_HAND: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register, advanced only on ready cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)   ph_q <= PH_IDLE;
        else if (rdy) ph_q <= ph_d;
    end

    // Opcode address capture at launch from idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pc_q <= '0;
        else if (rdy && ph_q == PH_IDLE && start) pc_q <= pc_in;
    end

    // Offset and condition capture at the end of the offset fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            take_q <= 1'b0;
        end else if (rdy && ph_q == PH_T1) begin
            off_q  <= data_in;
            take_q <= take;
        end
    end
endmodule

// File: rtl/brseq_bus.sv
// Module brseq_bus
// Output decode: selects the address-bus value for the current phase and
// classifies the byte read as the next opcode or as a thrown-away read.
// Also raises the hand-off flags. All inputs come from registers or from
// logic fed only by registers, so the outputs stay stable while stalled.
module brseq_bus
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  phase_e            ph_q,
    input  logic              take_q,
    input  logic              page_cross,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [ADDR_W-1:0] pc_p1,
    input  logic [ADDR_W-1:0] pc_p2,
    input  logic [ADDR_W-1:0] tgt_nocarry,
    input  logic [ADDR_W-1:0] tgt_full,
    input  logic [ADDR_W-1:0] seq_after_pc2,
    input  logic [ADDR_W-1:0] seq_after_tgt,
    output logic [ADDR_W-1:0] addr,
    output logic              next_op,
    output logic              discard,
    output logic              hand_t1f,
    output logic              hand_t1
);
    // Per-phase address and read classification.
    always_comb begin
        addr     = '0;
        next_op  = 1'b0;
        discard  = 1'b0;
        hand_t1f = 1'b0;
        hand_t1  = 1'b0;
        case (ph_q)
            PH_T0: addr = pc_q;
            PH_T1: addr = pc_p1;
            PH_T2: begin
                addr    = pc_p2;
                next_op = !take_q;
                discard = take_q;
            end
            PH_T3: begin
                addr    = tgt_nocarry;
                next_op = !page_cross;
                discard = page_cross;
            end
            PH_FIX: begin
                addr    = tgt_full;
                next_op = 1'b1;
            end
            PH_HAND: begin
                addr     = take_q ? seq_after_tgt : seq_after_pc2;
                hand_t1f = 1'b1;
                hand_t1  = take_q && page_cross;
            end
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/branch_cycle_seq.sv
// Module branch_cycle_seq
// Top of the relative branch cycle sequencer: phase machine, address
// arithmetic and output decode. Assumes the memory returns the offset
// byte during the offset-fetch phase and that the branch condition is
// resolved by the end of that phase.
module branch_cycle_seq
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [OFS_W-1:0]  data_in,
    input  logic              take,
    output logic [ADDR_W-1:0] addr,
    output logic              next_op,
    output logic              discard,
    output logic              hand_t1f,
    output logic              hand_t1,
    output logic [2:0]        phase
);
    phase_e            ph_q;
    logic [ADDR_W-1:0] pc_q;
    logic [OFS_W-1:0]  off_q;
    logic              take_q;
    logic [ADDR_W-1:0] pc_p1;
    logic [ADDR_W-1:0] pc_p2;
    logic [ADDR_W-1:0] tgt_nocarry;
    logic [ADDR_W-1:0] tgt_full;
    logic [ADDR_W-1:0] seq_after_pc2;
    logic [ADDR_W-1:0] seq_after_tgt;
    logic              page_cross;

    brseq_fsm #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy        (rdy),
        .start      (start),
        .pc_in      (pc_in),
        .data_in    (data_in),
        .take       (take),
        .page_cross (page_cross),
        .ph_q       (ph_q),
        .pc_q       (pc_q),
        .off_q      (off_q),
        .take_q     (take_q)
    );

    brseq_target #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_target (
        .pc_q          (pc_q),
        .off_q         (off_q),
        .pc_p1         (pc_p1),
        .pc_p2         (pc_p2),
        .tgt_nocarry   (tgt_nocarry),
        .tgt_full      (tgt_full),
        .seq_after_pc2 (seq_after_pc2),
        .seq_after_tgt (seq_after_tgt),
        .page_cross    (page_cross)
    );

    brseq_bus #(.ADDR_W(ADDR_W)) u_bus (
        .ph_q          (ph_q),
        .take_q        (take_q),
        .page_cross    (page_cross),
        .pc_q          (pc_q),
        .pc_p1         (pc_p1),
        .pc_p2         (pc_p2),
        .tgt_nocarry   (tgt_nocarry),
        .tgt_full      (tgt_full),
        .seq_after_pc2 (seq_after_pc2),
        .seq_after_tgt (seq_after_tgt),
        .addr          (addr),
        .next_op       (next_op),
        .discard       (discard),
        .hand_t1f      (hand_t1f),
        .hand_t1       (hand_t1)
    );

    // Expose the phase code at the port.
    assign phase = ph_q;
endmodule

// File: rtl/brseq_checker.sv
// Module brseq_checker
// Temporal properties of the branch sequencer, observed at its ports.
// Bound to every instance of branch_cycle_seq.
module brseq_checker
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy,
    input logic [ADDR_W-1:0] addr,
    input logic              next_op,
    input logic              discard,
    input logic              hand_t1f,
    input logic              hand_t1,
    input logic [2:0]        phase
);
    assert_op_discard_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(next_op && discard));

    assert_t1_needs_t1f_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hand_t1 |-> hand_t1f);

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> ($stable(addr) && $stable(phase) && $stable(next_op) &&
                  $stable(discard) && $stable(hand_t1f) && $stable(hand_t1)));

    assert_t0_to_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T0 && rdy) |=> (phase == PH_T1));

    assert_hand_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HAND && rdy) |=> (phase == PH_IDLE));

    assert_discard_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> (phase == PH_T2 || phase == PH_T3));

    assert_fix_fetches_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIX) |-> next_op);

    assert_fix_after_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && discard && rdy) |=> (phase == PH_FIX));
endmodule

bind branch_cycle_seq brseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy      (rdy),
    .addr     (addr),
    .next_op  (next_op),
    .discard  (discard),
    .hand_t1f (hand_t1f),
    .hand_t1  (hand_t1),
    .phase    (phase)
);

// File: tb/branch_cycle_seq_test.sv
// Bench for branch_cycle_seq: sweeps every offset byte, both branch
// conditions and a set of program counters on page edges, with stalls and
// stray inputs mixed in. Expected values come from plain arithmetic.
module branch_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  data_in = 8'h00;
    logic        take = 1'b0;
    logic [15:0] addr;
    logic        next_op;
    logic        discard;
    logic        hand_t1f;
    logic        hand_t1;
    logic [2:0]  phase;

    int vectors = 0;
    int fails = 0;

    branch_cycle_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdy      (rdy),
        .start    (start),
        .pc_in    (pc_in),
        .data_in  (data_in),
        .take     (take),
        .addr     (addr),
        .next_op  (next_op),
        .discard  (discard),
        .hand_t1f (hand_t1f),
        .hand_t1  (hand_t1),
        .phase    (phase)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Compare all outputs with expected values.
    task automatic chk(input logic [15:0] ea, input logic eo, input logic ed,
                       input logic ef, input logic e1, input logic [2:0] eph,
                       input string tag);
        vectors++;
        if (addr !== ea || next_op !== eo || discard !== ed ||
            hand_t1f !== ef || hand_t1 !== e1 || phase !== eph) begin
            fails++;
            $display("FAIL %s: actual addr=%h op=%b dis=%b t1f=%b t1=%b ph=%0d expected addr=%h op=%b dis=%b t1f=%b t1=%b ph=%0d",
                     tag, addr, next_op, discard, hand_t1f, hand_t1, phase,
                     ea, eo, ed, ef, e1, eph);
        end
    endtask

    // One sequencer cycle: check, drive, optionally stall with garbage inputs, advance.
    task automatic step(input logic [15:0] ea, input logic eo, input logic ed,
                        input logic ef, input logic e1, input logic [2:0] eph,
                        input logic [7:0] d, input logic tk, input logic stall,
                        input string tag);
        chk(ea, eo, ed, ef, e1, eph, tag);
        data_in = d;
        take    = tk;
        if (stall) begin
            rdy     = 1'b0;
            data_in = ~d;
            take    = ~tk;
            start   = 1'b1;
            @(posedge clk);
            #2;
            chk(ea, eo, ed, ef, e1, eph, {"R9 stall hold, ", tag});
            rdy     = 1'b1;
            data_in = d;
            take    = tk;
            start   = (eph != 3'd6);
        end
        @(posedge clk);
        #2;
    endtask

    // Full branch from launch to idle, expected values computed arithmetically.
    task automatic run(input logic [15:0] pc, input logic [7:0] off, input logic tk);
        logic [15:0] pc2, tgt, unc, hnd;
        logic        cr;
        logic [2:0]  sel;
        pc2 = pc + 16'd2;
        tgt = pc2 + {{8{off[7]}}, off};
        unc = {pc2[15:8], tgt[7:0]};
        cr  = (tgt[15:8] != pc2[15:8]);
        hnd = (tk ? tgt : pc2) + 16'd1;
        sel = off[2:0];
        pc_in = pc;
        start = 1'b1;
        @(posedge clk);
        #2;
        // R10: stray launches with a wrong pc while busy on some runs.
        start = (off[4:3] == 2'b01);
        pc_in = ~pc;
        step(pc, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'hA5, ~tk, sel == 3'd3, "R2 opcode fetch");
        step(pc + 16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, off, tk, sel == 3'd6, "R3 offset fetch");
        step(pc2, !tk, tk, 1'b0, 1'b0, 3'd3, ~off, ~tk, sel == 3'd5,
             tk ? "R5 third cycle taken" : "R4 third cycle not taken");
        if (tk) begin
            step(unc, !cr, cr, 1'b0, 1'b0, 3'd4, ~off, ~tk, sel == 3'd7,
                 cr ? "R7 fourth cycle crossing" : "R6 fourth cycle same page");
            if (cr)
                step(tgt, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5, ~off, ~tk, sel == 3'd2,
                     "R7 carry-fix cycle");
        end
        start = 1'b0;
        step(hnd, 1'b0, 1'b0, 1'b1, tk && cr, 3'd6, ~off, ~tk, sel == 3'd4,
             tk ? (cr ? "R7 hand-off long form" : "R6 hand-off same page")
                : "R4 hand-off not taken");
        chk(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R8 R10 back to idle");
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog: actual run still active expected finished");
        report();
        $finish;
    end

    // Main sequence.
    initial begin
        logic [15:0] pcs [8];
        pcs[0] = 16'h0000; pcs[1] = 16'h00FD; pcs[2] = 16'h00FE; pcs[3] = 16'h00FF;
        pcs[4] = 16'h1234; pcs[5] = 16'h7F80; pcs[6] = 16'hFFFD; pcs[7] = 16'hFFFF;
        rst_n = 1'b0;
        start = 1'b1;
        pc_in = 16'hBEEF;
        repeat (3) @(posedge clk);
        #2;
        chk(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R1 reset state");
        start = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R1 idle after reset");
        // R9: a launch request while stalled in idle is ignored.
        rdy = 1'b0;
        start = 1'b1;
        @(posedge clk);
        #2;
        chk(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R9 launch blocked by stall");
        start = 1'b0;
        rdy = 1'b1;
        for (int p = 0; p < 8; p++) begin
            for (int o = 0; o < 256; o++) begin
                for (int t = 0; t < 2; t++) begin
                    run(pcs[p], 8'(o), t[0]);
                end
            end
        end
        report();
        $finish;
    end
endmodule